// File: doc/BRIEF.md
# DMA Request Recognition Unit

This unit decides, for one DMA channel, whether an external peripheral has a valid request waiting. When it has, the unit asks an arbiter for the system bus, waits for the grant, and then runs device accesses with an acknowledge raised toward the peripheral. Near the end of each access a phase strobe from the bus cycle logic marks the sample point. At that point the unit decides whether to start the next operand at once, keeping the bus, or to give the bus back.

The request pin is active low and has two modes. In level mode the peripheral holds the pin low for as long as it wants service. In cycle-steal mode each high-to-low transition of the pin stands for one operand. A packing option makes one operand span several narrow device accesses. The request is then judged only at the strobe of the final access of the operand. Address generation, data movement, arbitration and byte counting belong to other blocks.

Top module: `dma_req_recog`

## Requirements
- R1: After reset the unit is idle, with `bus_req_o` and `ack_o` low and no cycle-steal request latched. A pin that stays high, in either mode, raises no bus request.
- R2: A recognized request raises `bus_req_o`. `ack_o` rises only in the cycle after `bus_grant_i` is seen high, and it is never high while the grant is low.
- R3: From the grant until the transfer ends, `ack_o` stays high without a gap across every access and every chained operand. A transfer ends only on a clock edge at which `sample_i` was high.
- R4: In level mode (`mode_i` = 0), a pin that is low (asserted) at the final sample strobe of an operand makes the next operand start on the next cycle, with `bus_req_o` and `ack_o` kept high.
- R5: In level mode, a pin that is high at the final sample strobe makes `bus_req_o` and `ack_o` both fall on the next clock edge.
- R6: With `pack_i` = 1, one operand is PACK_BEATS device accesses. Sample strobes before the last access always continue the operand, and the request is judged only at the strobe of the last access. With `pack_i` = 0, every access is a whole operand.
- R7: In cycle-steal mode (`mode_i` = 1), each high-to-low transition of the pin is one operand request. A pin held low gives exactly one operand.
- R8: In cycle-steal mode, transitions that arrive while the unit waits for the grant (before `ack_o` rises) are dropped and do not cause extra operands.
- R9: In cycle-steal mode, a transition seen while `ack_o` is high, up to and including the final strobe cycle, chains one more operand before the bus is released. Without such a transition the bus is released after the strobe.
- R10: The pin passes through SYNC_STAGES flops before it is used. With the default of 2, a pin that falls in an idle cycle raises `bus_req_o` on the third clock edge after the change. `mode_i` and `pack_i` change only while `bus_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 1 | Request mode: 0 level, 1 cycle-steal |
| pack_i | input | 1 | 1: one operand spans PACK_BEATS accesses |
| dreq_n_i | input | 1 | Peripheral request, active low, asynchronous |
| sample_i | input | 1 | Sample-point strobe of the current device access |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| bus_req_o | output | 1 | Bus request toward the arbiter |
| ack_o | output | 1 | Acknowledge toward the peripheral during each access |

## Verification
The bench builds the unit with SYNC_STAGES = 2 and PACK_BEATS = 2. With two stages, the point where a request that changes at the start of an access just misses or just makes the strobe falls on exact, fixed cycles, so the bench can place its pin changes on either side of that point. With two beats, a packed operand has a first strobe that must be skipped, so a level request withdrawn before that first strobe must still finish the second access. The bench pairs these with long grant delays, which leave room for extra cycle-steal pulses before the acknowledge rises.

// File: rtl/dma_req_recog_pkg.sv
package dma_req_recog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSREQ = 2'd1,
        ST_XFER   = 2'd2
    } recog_state_e;

    typedef struct packed {
        recog_state_e st;
        logic         pend;
    } recog_ctl_t;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    output logic req_o,
    output logic edge_o
);
    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    localparam int LAST = STAGES;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LAST-1:0], ~req_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign req_o  = chain_q[LAST-1];
    assign edge_o = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/dreq_beat_ctr.sv
module dreq_beat_ctr #(
    parameter int BEATS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pack_i,
    input  logic step_i,
    input  logic clr_i,
    output logic last_o
);
    generate
        if (BEATS > 1) begin : g_multi
            localparam int W = $clog2(BEATS);
            localparam logic [W-1:0] TOP = W'(BEATS - 1);

            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr_i)       cnt_d = '0;
                else if (step_i) cnt_d = last_o ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign last_o = !pack_i || (cnt_q == TOP);
        end else begin : g_single
            logic unused_in;
            assign unused_in = &{clk, rst_n, pack_i, step_i, clr_i};
            assign last_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/dma_req_recog.sv
module dma_req_recog
    import dma_req_recog_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PACK_BEATS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic pack_i,
    input  logic dreq_n_i,
    input  logic sample_i,
    input  logic bus_grant_i,
    output logic bus_req_o,
    output logic ack_o
);
    logic req_lvl, req_edge, beat_last, pend_now;
    recog_ctl_t ctl_d, ctl_q;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_n_i (dreq_n_i),
        .req_o   (req_lvl),
        .edge_o  (req_edge)
    );

    dreq_beat_ctr #(.BEATS(PACK_BEATS)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .pack_i (pack_i),
        .step_i (ack_o && sample_i),
        .clr_i  (!ack_o),
        .last_o (beat_last)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.pend = 1'b0;
                if (mode_i ? req_edge : req_lvl) ctl_d.st = ST_BUSREQ;
            end
            ST_BUSREQ: begin
                // edges here belong to the request already being served
                ctl_d.pend = 1'b0;
                if (bus_grant_i) ctl_d.st = ST_XFER;
            end
            ST_XFER: begin
                ctl_d.pend = mode_i & (ctl_q.pend | req_edge);
                if (sample_i && beat_last) begin
                    ctl_d.pend = 1'b0;
                    if (!(mode_i ? (ctl_q.pend | req_edge) : req_lvl))
                        ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st   = ST_IDLE;
                ctl_d.pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.pend <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_req_o = (ctl_q.st != ST_IDLE);
    assign ack_o     = (ctl_q.st == ST_XFER);
    assign pend_now  = ctl_q.pend;

endmodule

// File: rtl/dma_req_recog_chk.sv
module dma_req_recog_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_i,
    input logic pack_i,
    input logic sample_i,
    input logic bus_grant_i,
    input logic bus_req_o,
    input logic ack_o,
    input logic req_lvl,
    input logic req_edge,
    input logic pend_now,
    input logic beat_last
);
    logic final_strobe;
    assign final_strobe = ack_o && sample_i && beat_last;

    assert_ack_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> bus_grant_i);

    assert_bus_before_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(bus_req_o));

    assert_ack_ends_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(sample_i));

    assert_level_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && final_strobe && req_lvl) |=> ack_o);

    assert_level_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && final_strobe && !req_lvl) |=> !bus_req_o);

    assert_packed_continue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && sample_i && !beat_last) |=> ack_o);

    assert_steal_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && final_strobe && (pend_now || req_edge)) |=> ack_o);

    assert_steal_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && final_strobe && !pend_now && !req_edge) |=> !bus_req_o);

    assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> ($stable(mode_i) && $stable(pack_i)));

endmodule

bind dma_req_recog dma_req_recog_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .pack_i      (pack_i),
    .sample_i    (sample_i),
    .bus_grant_i (bus_grant_i),
    .bus_req_o   (bus_req_o),
    .ack_o       (ack_o),
    .req_lvl     (req_lvl),
    .req_edge    (req_edge),
    .pend_now    (pend_now),
    .beat_last   (beat_last)
);

// File: tb/dma_req_recog_test.sv
module dma_req_recog_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0;
    logic pack_i = 1'b0;
    logic dreq_n = 1'b1;
    logic sample = 1'b0;
    logic grant = 1'b0;
    logic bus_req, ack;

    always #4 clk = ~clk;

    dma_req_recog #(.SYNC_STAGES(2), .PACK_BEATS(2)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .pack_i      (pack_i),
        .dreq_n_i    (dreq_n),
        .sample_i    (sample),
        .bus_grant_i (grant),
        .bus_req_o   (bus_req),
        .ack_o       (ack)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bus, strobe and device model, all driven on the falling edge
    int ph = 0, strobes = 0, plow = 0, pulses_left = 0, kick = 0, gapc = 0;
    int gdly = 0, gcnt = 0, viol = 0, beats = 1, ackcyc = 0, lvl_thr = 0;
    bit lvl_on = 1'b0;

    always @(negedge clk) begin
        if (ack && !grant) viol++;
        if (bus_req) begin
            if (gcnt >= gdly) grant = 1'b1;
            else gcnt++;
        end else begin
            grant = 1'b0;
            gcnt = 0;
        end
        if (ack) begin
            ackcyc++;
            if (ph == 0 && pulses_left > 0 && (strobes % beats) == 0) begin
                plow = 2;
                pulses_left--;
            end
            if (ph == 0 && lvl_on && strobes >= lvl_thr) lvl_on = 1'b0;
            sample = (ph == 3);
            if (ph == 3) strobes++;
            ph = (ph == 3) ? 0 : ph + 1;
        end else begin
            sample = 1'b0;
            ph = 0;
        end
        if (gapc > 0) gapc--;
        if (kick > 0 && plow == 0 && gapc == 0) begin
            plow = 2;
            kick--;
            gapc = 4;
        end
        if (plow > 0) begin
            dreq_n = 1'b0;
            plow--;
        end else begin
            dreq_n = !lvl_on;
        end
    end

    // mode, pack, grant delay, extra pulses before grant, operands wanted
    localparam int NV = 9;
    localparam int VEC [NV][5] = '{
        '{0, 0, 2, 0, 1},
        '{0, 0, 0, 0, 3},
        '{0, 1, 3, 0, 2},
        '{0, 1, 0, 0, 1},
        '{1, 0, 2, 0, 1},
        '{1, 0, 1, 0, 4},
        '{1, 1, 2, 0, 3},
        '{1, 0, 20, 3, 1},
        '{1, 1, 20, 2, 2}
    };

    task automatic run_vec(input int m, input int pk, input int gd, input int xtra,
                           input int nops, input string tag);
        @(posedge clk); #1;
        mode_i = m[0];
        pack_i = pk[0];
        beats = (pk != 0) ? 2 : 1;
        gdly = gd;
        strobes = 0;
        viol = 0;
        ackcyc = 0;
        if (m != 0) begin
            kick = 1 + xtra;
            pulses_left = nops - 1;
        end else begin
            lvl_thr = (nops - 1) * beats;
            lvl_on = 1'b1;
        end
        wait (bus_req == 1'b1);
        wait (bus_req == 1'b0);
        repeat (16) @(posedge clk);
        #1;
        chk(strobes == nops * beats, tag, strobes, nops * beats);
        chk(viol == 0, "R2", viol, 0);
        chk(ackcyc == 4 * nops * beats, "R3", ackcyc, 4 * nops * beats);
        chk(!bus_req && !ack, (m != 0) ? "R9" : "R5", int'(bus_req), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        // R1: idle after reset, pin high in both modes
        chk(bus_req == 1'b0, "R1", int'(bus_req), 0);
        chk(ack == 1'b0, "R1", int'(ack), 0);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        chk(bus_req == 1'b0, "R1", int'(bus_req), 0);
        mode_i = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        chk(bus_req == 1'b0, "R1", int'(bus_req), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            if (VEC[i][3] > 0) tag = "R8";
            else if (VEC[i][1] != 0) tag = "R6";
            else if (VEC[i][0] != 0) tag = "R9";
            else tag = "R4";
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], tag);
        end

        // R7: cycle-steal with the pin held low gives a single operand
        @(posedge clk); #1;
        mode_i = 1'b1; pack_i = 1'b0; beats = 1; gdly = 1;
        strobes = 0; viol = 0;
        lvl_thr = 1000;
        lvl_on = 1'b1;
        wait (bus_req == 1'b1);
        wait (bus_req == 1'b0);
        repeat (20) @(posedge clk);
        #1;
        chk(strobes == 1, "R7", strobes, 1);
        chk(bus_req == 1'b0, "R7", int'(bus_req), 0);
        lvl_on = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        chk(bus_req == 1'b0, "R7", int'(bus_req), 0);

        // R10: two-stage synchronizer latency in level mode
        mode_i = 1'b0; gdly = 0; strobes = 0;
        lvl_thr = 0;
        lvl_on = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk(bus_req == 1'b0, "R10", int'(bus_req), 0);
        @(posedge clk); #1;
        chk(bus_req == 1'b1, "R10", int'(bus_req), 1);
        wait (bus_req == 1'b0);
        repeat (10) @(posedge clk);
        #1;
        chk(strobes == 1, "R10", strobes, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule